// File: doc/BRIEF.md
# Page-Buffered Flash Array Emulator

A synchronous, register-based model of a small page-organised nonvolatile memory, for use in place of a real flash macro when system behaviour is being developed. All traffic passes through a single page buffer. Writes land only in that buffer, and a separate program command commits the buffer to the array page it was loaded from. Each page holds 128 data bytes (eight 16-byte blocks) plus one 16-byte auxiliary block. The auxiliary block carries a per-page protect flag. Each page also has a program counter that reports wear once a threshold is reached.

Every operation is sampled on the rising clock edge while `busy` is low, and then holds `busy` high for a fixed number of cycles. When `busy` falls, `rdata` and `status` carry that operation's result. Two policy inputs, `keep_guard` and `seal_on_prog`, are used while the block runs. `keep_guard` stops a modified buffer from being lost. `seal_on_prog` makes each program mark its page as protected.

Top module: `paged_nvm_model`

## Requirements
- R1: While `rst_n` is low, and after it is released, `busy` is 0, `status` is 00 and `rdata` is 0. Reset also clears the array, the program counters and the buffer. Reset taken during a busy operation ends it.
- R2: A write changes only the buffer; the array page keeps its old contents until a program addressed to the page held in the buffer. Such a program holds `busy` for PROG_CYC cycles and reports 00. A program or overwrite addressed to a page the buffer does not hold is refused with status 01. A read of the page held in the buffer returns the buffer contents.
- R3: `width` 00 moves one byte on bits [7:0], 01 moves two bytes on [15:0], and 10 or 11 move four bytes on [31:0]. The byte at the address goes on bits [7:0] and following bytes go on higher lanes. Unused read lanes are zero. Byte addresses wrap within the 128-byte data area, or within the 16-byte auxiliary block when `aux_sel` is 1.
- R4: Erase sets all 144 bytes of the addressed page to zero, holds `busy` for ERASE_CYC cycles and drops the buffer if it held that page.
- R5: Two commands load a page into the buffer first and hold `busy` for COPY_CYC (65) cycles: a write to a page the buffer does not hold, and unprotect. A write to the page already held takes 1 cycle.
- R6: A read holds `busy` for RD_CYC (4) cycles, or RD_PIPE_CYC (6) cycles with `rd_pipe`. `rdata` changes only on the edge where `busy` falls, and `status` does not change while `busy` stays high.
- R7: With `keep_guard` set and a modified buffer holding page A, a write, erase or unprotect addressed to any other page is refused in 1 cycle with status 01 and changes nothing. A discard (1 cycle) empties the buffer so the access can proceed.
- R8: The protect flag is bit 0 of byte 0 of a page's auxiliary block. A program made with `seal_on_prog` set stores the flag as 1. A program or overwrite of a page whose stored flag is 1 is refused with 01, unless the buffer was loaded by unprotect. Overwrite never sets the flag by itself.
- R9: Each successful program or overwrite increments that page's counter, which saturates at 255. The operation still commits, but status is 10 when the new count is WR_THR (10) or more.
- R10: Commands that arrive while `busy` is high are ignored. When several strobes are high together, the one acted on is chosen in this order: discard, erase, program, overwrite, unprotect, write, read.
- R11: A read with `rd_next` returns the item at the address plus the access width in bytes.
- R12: A read with `pg_stat` returns a page status word. Bit 0 is the stored protect flag, bit 1 is set when the buffer holds the page and it is modified, bits [15:8] are the program count, and all other bits are zero. Status takes only the values 00, 01 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW (9) | {page, byte offset[6:0]} |
| aux_sel | input | 1 | Address the auxiliary block of the page |
| wdata | input | 32 | Write data |
| width | input | 2 | Access width code |
| rd_req | input | 1 | Read |
| rd_next | input | 1 | With read: use the following address |
| rd_pipe | input | 1 | With read: pipelined timing |
| pg_stat | input | 1 | With read: return page status word |
| wr_req | input | 1 | Write into buffer |
| erase_req | input | 1 | Erase page |
| prog_req | input | 1 | Program buffer into page |
| ovw_req | input | 1 | Overwrite page with buffer |
| unprot_req | input | 1 | Load page into buffer as writeable |
| discard_req | input | 1 | Empty the buffer |
| keep_guard | input | 1 | Page-loss guard enable |
| seal_on_prog | input | 1 | Program sets the protect flag |
| rdata | output | 32 | Read result, valid when busy is 0 |
| busy | output | 1 | Operation in progress |
| status | output | 2 | Result of last completed operation |

## Verification
On every cycle, the embedded assertions check four things. `rdata` and `status` hold still for as long as `busy` stays high. Status never takes the value 11. No busy period is longer than the longest operation. The buffer's modified and unlocked flags are never set without a loaded page. The bench's scenarios show the rest: the arithmetic data sweep over all pages and widths, the exact busy length of each operation, guard and protect refusals, the threshold crossing on the tenth program, and strobe priority. They also show that commands issued during a copy are ignored.

// File: rtl/paged_nvm_model.sv
module paged_nvm_model #(
  parameter int PAGES       = 4,
  parameter int WR_THR      = 10,
  parameter int COPY_CYC    = 65,
  parameter int PROG_CYC    = 20,
  parameter int ERASE_CYC   = 16,
  parameter int RD_CYC      = 4,
  parameter int RD_PIPE_CYC = 6,
  localparam int PGW = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int AW  = PGW + 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          aux_sel,
  input  logic [31:0]   wdata,
  input  logic [1:0]    width,
  input  logic          rd_req,
  input  logic          rd_next,
  input  logic          rd_pipe,
  input  logic          pg_stat,
  input  logic          wr_req,
  input  logic          erase_req,
  input  logic          prog_req,
  input  logic          ovw_req,
  input  logic          unprot_req,
  input  logic          discard_req,
  input  logic          keep_guard,
  input  logic          seal_on_prog,
  output logic [31:0]   rdata,
  output logic          busy,
  output logic [1:0]    status
);
  localparam int DB   = 128;
  localparam int PB   = DB + 16;
  localparam int CW   = 8;
  localparam int M1   = (COPY_CYC > PROG_CYC) ? COPY_CYC : PROG_CYC;
  localparam int M2   = (ERASE_CYC > RD_PIPE_CYC) ? ERASE_CYC : RD_PIPE_CYC;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXN = (M3 > RD_CYC) ? M3 : RD_CYC;
  localparam int TMW  = $clog2(MAXN + 2);

  logic [7:0]     arr  [PAGES*PB];
  logic [7:0]     pbuf [PB];
  logic [CW-1:0]  pcnt [PAGES];
  logic           bval, bmod, bunl;
  logic [PGW-1:0] bpg;
  logic [TMW-1:0] tmr;
  logic [1:0]     st_pend;
  logic [31:0]    rd_pend;

  logic [PGW-1:0] pg;
  logic [6:0]     off, roff;
  logic [2:0]     nb;
  logic           hold, guard_hit, prot, cmd;
  int             base;
  logic [CW-1:0]  ncnt;
  logic [31:0]    rdv, psw;

  function automatic int bix(input logic [6:0] o, input logic a, input int j);
    logic [6:0] s;
    s = o + 7'(j);
    return a ? DB + int'(s[3:0]) : int'(s);
  endfunction

  assign pg        = addr[AW-1:7];
  assign off       = addr[6:0];
  assign nb        = (width == 2'b00) ? 3'd1 : (width == 2'b01) ? 3'd2 : 3'd4;
  assign roff      = rd_next ? off + 7'(nb) : off;
  assign base      = int'(pg) * PB;
  assign hold      = bval && (bpg == pg);
  assign guard_hit = keep_guard && bval && bmod && (bpg != pg);
  assign prot      = arr[base + DB][0];
  assign ncnt      = (pcnt[pg] == {CW{1'b1}}) ? pcnt[pg] : pcnt[pg] + 1'b1;
  assign busy      = (tmr != '0);
  assign cmd       = discard_req | erase_req | prog_req | ovw_req | unprot_req | wr_req | rd_req;
  assign psw       = {16'h0, pcnt[pg], 6'h0, hold && bmod, prot};

  always_comb begin
    rdv = '0;
    for (int j = 0; j < 4; j++)
      if (j < int'(nb))
        rdv[8*j +: 8] = hold ? pbuf[bix(roff, aux_sel, j)] : arr[base + bix(roff, aux_sel, j)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGES*PB; i++) arr[i] <= '0;
      for (int i = 0; i < PB; i++) pbuf[i] <= '0;
      for (int i = 0; i < PAGES; i++) pcnt[i] <= '0;
      bval <= 1'b0; bmod <= 1'b0; bunl <= 1'b0; bpg <= '0;
      tmr <= '0; st_pend <= 2'b00; rd_pend <= '0;
      rdata <= '0; status <= 2'b00;
    end else if (busy) begin
      tmr <= tmr - 1'b1;
      if (tmr == TMW'(1)) begin
        status <= st_pend;
        rdata  <= rd_pend;
      end
    end else if (cmd) begin
      tmr     <= TMW'(1);
      st_pend <= 2'b00;
      rd_pend <= rdata;
      if (discard_req) begin
        bval <= 1'b0; bmod <= 1'b0; bunl <= 1'b0;
      end else if (erase_req) begin
        if (guard_hit) st_pend <= 2'b01;
        else begin
          for (int i = 0; i < PB; i++) arr[base + i] <= '0;
          if (hold) begin bval <= 1'b0; bmod <= 1'b0; bunl <= 1'b0; end
          tmr <= TMW'(ERASE_CYC);
        end
      end else if (prog_req || ovw_req) begin
        if (!hold || (prot && !bunl)) st_pend <= 2'b01;
        else begin
          for (int i = 0; i < PB; i++) arr[base + i] <= pbuf[i];
          if (prog_req && seal_on_prog) begin
            arr[base + DB] <= pbuf[DB] | 8'h01;
            pbuf[DB]       <= pbuf[DB] | 8'h01;
          end
          pcnt[pg] <= ncnt;
          bmod     <= 1'b0;
          bunl     <= 1'b0;
          st_pend  <= (int'(ncnt) >= WR_THR) ? 2'b10 : 2'b00;
          tmr      <= TMW'(PROG_CYC);
        end
      end else if (unprot_req) begin
        if (guard_hit) st_pend <= 2'b01;
        else begin
          for (int i = 0; i < PB; i++) pbuf[i] <= arr[base + i];
          bval <= 1'b1; bpg <= pg; bmod <= 1'b0; bunl <= 1'b1;
          tmr  <= TMW'(COPY_CYC);
        end
      end else if (wr_req) begin
        if (guard_hit) st_pend <= 2'b01;
        else begin
          if (!hold) begin
            for (int i = 0; i < PB; i++) pbuf[i] <= arr[base + i];
            bval <= 1'b1; bpg <= pg; bunl <= 1'b0;
            tmr  <= TMW'(COPY_CYC);
          end
          for (int j = 0; j < 4; j++)
            if (j < int'(nb)) pbuf[bix(off, aux_sel, j)] <= wdata[8*j +: 8];
          bmod <= 1'b1;
        end
      end else begin
        rd_pend <= pg_stat ? psw : rdv;
        tmr     <= rd_pipe ? TMW'(RD_PIPE_CYC) : TMW'(RD_CYC);
      end
    end
  end

  logic [TMW:0] blen;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) blen <= '0;
    else blen <= blen + 1'b1;
  end

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(blen) <= MAXN);
  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rdata));
  // R6
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(status));
  // R12
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'b11);
  // R7
  mod_needs_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bmod |-> bval);
  // R8
  unlock_needs_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bunl |-> bval);
endmodule

// File: tb/paged_nvm_model_bench.sv
module paged_nvm_model_bench;
  localparam int PAGES = 4, WR_THR = 10, COPY = 65, PROG = 20, ERASE = 16, RDC = 4, RDP = 6;
  localparam int C_RD = 1, C_NX = 2, C_PI = 4, C_PS = 8, C_WR = 16, C_ER = 32,
                 C_PG = 64, C_OW = 128, C_UP = 256, C_DS = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [8:0] addr = '0;
  logic aux_sel = 1'b0;
  logic [31:0] wdata = '0;
  logic [1:0] width = '0;
  logic rd_req = 0, rd_next = 0, rd_pipe = 0, pg_stat = 0, wr_req = 0, erase_req = 0;
  logic prog_req = 0, ovw_req = 0, unprot_req = 0, discard_req = 0;
  logic keep_guard = 0, seal_on_prog = 0;
  logic [31:0] rdata;
  logic busy;
  logic [1:0] status;
  int n_chk = 0, n_bad = 0, cyc;
  int cnt [PAGES];

  always #2 clk = ~clk;

  paged_nvm_model u_paged_nvm_model (
    .clk, .rst_n, .addr, .aux_sel, .wdata, .width, .rd_req, .rd_next, .rd_pipe,
    .pg_stat, .wr_req, .erase_req, .prog_req, .ovw_req, .unprot_req, .discard_req,
    .keep_guard, .seal_on_prog, .rdata, .busy, .status);

  function automatic logic [7:0] f(input int p, input int b);
    return 8'(p*16 + b*3 + 7);
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic drive(input int c, input int p, input int o, input bit ax, input int w, input logic [31:0] d);
    addr = 9'(p*128 + o); aux_sel = ax; width = 2'(w); wdata = d;
    {discard_req, unprot_req, ovw_req, prog_req, erase_req, wr_req, pg_stat, rd_pipe, rd_next, rd_req} = 10'(c);
  endtask

  task automatic op(input int c, input int p, input int o, input bit ax, input int w, input logic [31:0] d);
    @(negedge clk);
    drive(c, p, o, ax, w, d);
    @(posedge clk); #1;
    drive(0, p, o, ax, w, d);
    cyc = 0;
    @(negedge clk);
    while (busy) begin cyc++; @(negedge clk); end
  endtask

  task automatic rd(input string r, input int p, input int o, input int w, input logic [31:0] exp);
    op(C_RD, p, o, 0, w, 0);
    chk(r, rdata, exp);
  endtask

  initial begin
    #(4*190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < PAGES; i++) cnt[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 busy", 32'(busy), 0); chk("R1 status", 32'(status), 0); chk("R1 rdata", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after release", 32'(busy), 0);

    // R3 / R2 / R5: fill every page with 4-byte writes, then program
    for (int p = 0; p < PAGES; p++) begin
      for (int w = 0; w < 32; w++) begin
        op(C_WR, p, 4*w, 0, 2, {f(p,4*w+3), f(p,4*w+2), f(p,4*w+1), f(p,4*w)});
        if (w == 0) chk("R5 copy busy", cyc, COPY);
        if (w == 1) chk("R5 held write busy", cyc, 1);
      end
      op(C_PG, p, 0, 0, 0, 0);
      cnt[p]++;
      chk("R2 program busy", cyc, PROG);
      chk("R2 program status", 32'(status), 0);
    end
    op(C_DS, 0, 0, 0, 0, 0);
    chk("R7 discard busy", cyc, 1);

    // R3 byte sweep over every page (array path)
    for (int p = 0; p < PAGES; p++)
      for (int b = 0; b < 128; b++) begin
        rd("R3 byte read", p, b, 0, {24'h0, f(p,b)});
        if (p == 0 && b == 0) chk("R6 read busy", cyc, RDC);
      end
    for (int b = 0; b < 128; b += 2) rd("R3 half read", 2, b, 1, {16'h0, f(2,b+1), f(2,b)});
    rd("R3 word code 11", 3, 8, 3, {f(3,11), f(3,10), f(3,9), f(3,8)});
    rd("R3 wrap", 1, 127, 1, {16'h0, f(1,0), f(1,127)});
    op(C_RD | C_PI, 1, 20, 0, 0, 0);
    chk("R6 pipe busy", cyc, RDP);
    chk("R6 pipe data", rdata, {24'h0, f(1,20)});
    // R11
    op(C_RD | C_NX, 0, 10, 0, 0, 0);
    chk("R11 next byte", rdata, {24'h0, f(0,11)});
    op(C_RD | C_NX, 0, 8, 0, 2, 0);
    chk("R11 next word", rdata, {f(0,15), f(0,14), f(0,13), f(0,12)});

    // R2: buffer only until program
    op(C_WR, 0, 0, 0, 0, 32'h0000_00AA);
    chk("R2 copy busy", cyc, COPY);
    rd("R2 buffered read", 0, 0, 0, 32'hAA);
    op(C_DS, 0, 0, 0, 0, 0);
    rd("R2 array untouched", 0, 0, 0, {24'h0, f(0,0)});
    op(C_PG, 0, 0, 0, 0, 0);
    chk("R2 program without buffer refused", 32'(status), 1);
    rd("R2 still untouched", 0, 0, 0, {24'h0, f(0,0)});

    // R4 erase
    op(C_ER, 2, 0, 0, 0, 0);
    chk("R4 erase busy", cyc, ERASE);
    chk("R4 erase status", 32'(status), 0);
    for (int b = 0; b < 128; b += 4) rd("R4 zero data", 2, b, 2, 0);
    op(C_RD, 2, 0, 1, 2, 0);
    chk("R4 zero aux", rdata, 0);

    // R12 page status
    op(C_RD | C_PS, 1, 0, 0, 0, 0);
    chk("R12 status word", rdata, 32'h0000_0100);

    // R7 page-loss guard
    keep_guard = 1'b1;
    op(C_WR, 0, 0, 0, 0, 32'h33);
    op(C_WR, 1, 0, 0, 0, 32'h44);
    chk("R7 write refused busy", cyc, 1);
    chk("R7 write refused", 32'(status), 1);
    op(C_ER, 1, 0, 0, 0, 0);
    chk("R7 erase refused", 32'(status), 1);
    rd("R7 page kept", 1, 0, 0, {24'h0, f(1,0)});
    op(C_RD | C_PS, 0, 0, 0, 0, 0);
    chk("R12 modified bit", rdata, 32'h0000_0102);
    op(C_DS, 0, 0, 0, 0, 0);
    op(C_WR, 1, 0, 0, 0, 32'h55);
    chk("R7 after discard", 32'(status), 0);
    chk("R7 after discard busy", cyc, COPY);
    op(C_DS, 0, 0, 0, 0, 0);
    keep_guard = 1'b0;

    // R8 protect flag
    seal_on_prog = 1'b1;
    op(C_WR, 3, 0, 0, 0, 32'h11);
    op(C_PG, 3, 0, 0, 0, 0); cnt[3]++;
    chk("R8 sealed program", 32'(status), 0);
    seal_on_prog = 1'b0;
    op(C_RD | C_PS, 3, 0, 0, 0, 0);
    chk("R8 flag set", rdata, {16'h0, 8'(cnt[3]), 8'h01});
    op(C_WR, 3, 1, 0, 0, 32'h22);
    chk("R8 held write", cyc, 1);
    op(C_PG, 3, 0, 0, 0, 0);
    chk("R8 program refused", 32'(status), 1);
    op(C_OW, 3, 0, 0, 0, 0);
    chk("R8 overwrite refused", 32'(status), 1);
    op(C_DS, 0, 0, 0, 0, 0);
    rd("R8 page kept", 3, 1, 0, {24'h0, f(3,1)});
    op(C_UP, 3, 0, 0, 0, 0);
    chk("R5 unprotect busy", cyc, COPY);
    op(C_WR, 3, 1, 0, 0, 32'h22);
    op(C_OW, 3, 0, 0, 0, 0); cnt[3]++;
    chk("R8 overwrite after unprotect", 32'(status), 0);
    op(C_DS, 0, 0, 0, 0, 0);
    rd("R8 overwrite committed", 3, 0, 2, {f(3,3), f(3,2), 8'h22, 8'h11});

    // R9 threshold
    op(C_WR, 1, 0, 0, 0, 32'h55);
    while (cnt[1] < WR_THR + 1) begin
      op(C_PG, 1, 0, 0, 0, 0); cnt[1]++;
      chk("R9 program status", 32'(status), (cnt[1] >= WR_THR) ? 2 : 0);
    end
    op(C_RD | C_PS, 1, 0, 0, 0, 0);
    chk("R9 count", rdata, {16'h0, 8'(cnt[1]), 8'h00});
    op(C_DS, 0, 0, 0, 0, 0);

    // R10 ignored while busy
    @(negedge clk); drive(C_WR, 0, 5, 0, 0, 32'h77);
    @(negedge clk); drive(0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    drive(C_ER, 1, 0, 0, 0, 0);
    @(negedge clk); drive(0, 0, 0, 0, 0, 0);
    while (busy) @(negedge clk);
    rd("R10 erase ignored", 1, 0, 0, 32'h55);
    op(C_DS | C_WR, 0, 5, 0, 0, 32'h99);
    chk("R10 priority busy", cyc, 1);
    op(C_RD | C_PS, 0, 0, 0, 0, 0);
    chk("R10 discard wins", rdata, {16'h0, 8'(cnt[0]), 8'h00});

    // R1 reset mid-operation
    @(negedge clk); drive(C_WR, 2, 0, 0, 0, 32'h1);
    @(negedge clk); drive(0, 0, 0, 0, 0, 0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 busy in reset", 32'(busy), 0);
    chk("R1 rdata in reset", rdata, 0);
    rst_n = 1'b1;
    rd("R1 array cleared", 1, 0, 0, 0);
    chk("R1 status", 32'(status), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule